// File: doc/BRIEF.md
# I2C Message Sequencer

This block drives a whole I2C read or write message through a byte-level I2C controller that reports its progress as 8-bit status codes. A client hands over a target address (7-bit, or 10-bit when enabled), a direction and a byte count. After every step the controller reports a status code, and the sequencer answers with exactly one action: issue a start, load the first or second address byte, load a data byte, continue, fetch a received byte, fetch the final byte and stop, or stop.

Outgoing data comes from a byte source. The sequencer samples `tx_byte` at the status that calls for it and pulses `tx_take` to consume it. Incoming bytes go out as one-cycle `rx_valid` beats. When the message ends the sequencer returns to idle, pulses `done` and holds a result code. For a read, the acknowledge bit that goes with each action drops as soon as a single byte remains, so the controller NACKs the last byte. A zero-length read ends right after the address is acknowledged, which makes it a presence probe.

Top module: `i2cseq_engine`

## Requirements
- R1: After reset the block is idle: `cmd_ready`=1, `act_valid`=0, `done`=0, `err_code`=0.
- R2: A request (`cmd_valid`) is taken only while `cmd_ready` is high. The cycle after it is taken, `act_valid`=1 with action START (code 2) and `cmd_ready`=0. A request made while busy has no effect.
- R3: A start (0x08) or repeated-start (0x10) status gives action ADDR1 (code 3). In 7-bit mode its byte is {addr[6:0], rd}, where rd=1 means read.
- R4: In 10-bit mode, address byte 1 is {5'b11110, addr[9:8], rd}. An address-ACK status (0x18 write, 0x40 read) then gives action ADDR2 (code 4) with byte addr[7:0].
- R5: On a write ACK status (0x18 in 7-bit mode, 0xD0, 0x28) with bytes remaining, the action is SEND (code 5): the byte is `tx_byte`, `tx_take` pulses and the count drops by one. With none remaining, the action is STOP (code 0) and the message ends.
- R6: On a read address ACK (0x40 in 7-bit mode, 0xE0) with bytes remaining, the action is CONTINUE (code 1). Status 0x50 gives action RECV (code 6) and delivers the byte on `rx_data` with `rx_valid`. `act_ack` is 0 when exactly one byte remains after the step and 1 otherwise.
- R7: Status 0x58 gives action RECV_STOP (code 7). It delivers the final byte, ends the message and sets `err_code`=0.
- R8: A read with count 0 gives STOP at the address ACK and ends with `err_code`=0.
- R9: A NACK status (0x20, 0x30, 0x48) gives STOP and ends the message with `err_code`=1 (no device).
- R10: Any other status while busy gives STOP, pulses `ctrl_reset` and ends the message with `err_code`=2 (I/O error).
- R11: A status that arrives while idle gives only a STOP action. `done` stays low and `err_code` is unchanged.
- R12: `done` is high for exactly one cycle when a message ends. `err_code` holds until the next request is taken, which clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Request to start a message |
| cmd_ready | output | 1 | High while idle |
| cmd_addr | input | 10 | Target address |
| cmd_ten | input | 1 | Select 10-bit addressing |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_len | input | LEN_W | Byte count |
| st_valid | input | 1 | Controller reports a status code |
| st_code | input | 8 | Status code |
| st_rx_byte | input | 8 | Controller receive data register |
| act_valid | output | 1 | Action pulse for the controller |
| act_code | output | 3 | Action code |
| act_byte | output | 8 | Byte to load for ADDR1, ADDR2 or SEND |
| act_ack | output | 1 | ACK bit for the next received byte |
| ctrl_reset | output | 1 | Controller reset pulse on I/O error |
| tx_byte | input | 8 | Next outgoing data byte |
| tx_take | output | 1 | Outgoing byte consumed |
| rx_valid | output | 1 | Received byte valid |
| rx_data | output | 8 | Received byte |
| done | output | 1 | Message ended (one cycle) |
| err_code | output | 2 | 0 ok, 1 no device, 2 I/O error |

## Verification
The hardest conditions to reach are the ACK-bit transition in the middle of a read and the 10-bit paths. Both need a specific sequence of status codes, each arriving in a specific sequencer state. The bench acts as the controller: it answers every action with the status code a real bus would produce next. This walks the sequencer through 3-byte reads, 1-byte 10-bit reads and 10-bit writes, and `act_ack` is checked at every step. Stray statuses in idle and requests made while busy are injected between messages, and their effect is observed on the next action.

// File: rtl/i2cseq_pkg.sv
`timescale 1ns/1ps
package i2cseq_pkg;
   typedef enum logic [2:0] {
      S_IDLE, S_WSTART, S_WADDR1, S_WADDR2, S_WSACK, S_WDATA
   } seq_state_t;

   typedef enum logic [2:0] {
      A_STOP = 3'd0, A_CONT = 3'd1, A_START = 3'd2, A_ADDR1 = 3'd3,
      A_ADDR2 = 3'd4, A_SEND = 3'd5, A_RECV = 3'd6, A_RECV_STOP = 3'd7
   } act_t;

   localparam logic [7:0] ST_START   = 8'h08;
   localparam logic [7:0] ST_RSTART  = 8'h10;
   localparam logic [7:0] ST_WA_ACK  = 8'h18;
   localparam logic [7:0] ST_WA_NACK = 8'h20;
   localparam logic [7:0] ST_WD_ACK  = 8'h28;
   localparam logic [7:0] ST_WD_NACK = 8'h30;
   localparam logic [7:0] ST_RA_ACK  = 8'h40;
   localparam logic [7:0] ST_RA_NACK = 8'h48;
   localparam logic [7:0] ST_RD_ACK  = 8'h50;
   localparam logic [7:0] ST_RD_NACK = 8'h58;
   localparam logic [7:0] ST_WA2_ACK = 8'hD0;
   localparam logic [7:0] ST_RA2_ACK = 8'hE0;

   localparam logic [1:0] E_NONE  = 2'd0;
   localparam logic [1:0] E_NODEV = 2'd1;
   localparam logic [1:0] E_IO    = 2'd2;
endpackage

// File: rtl/i2cseq_addr_fmt.sv
`timescale 1ns/1ps
module i2cseq_addr_fmt #(
   parameter bit TEN_EN = 1'b1
) (
   input  logic [9:0] addr,
   input  logic       ten_req,
   input  logic       rd,
   output logic       ten_eff,
   output logic [7:0] byte1,
   output logic [7:0] byte2
);
   generate
      if (TEN_EN) begin : g_ten
         assign ten_eff = ten_req;
      end else begin : g_seven
         assign ten_eff = 1'b0;
      end
   endgenerate

   assign byte1 = ten_eff ? {5'b11110, addr[9:8], rd} : {addr[6:0], rd};
   assign byte2 = ten_eff ? addr[7:0] : 8'h00;
endmodule

// File: rtl/i2cseq_step.sv
`timescale 1ns/1ps
module i2cseq_step
   import i2cseq_pkg::*;
#(
   parameter int LEN_W = 8
) (
   input  seq_state_t       state,
   input  logic [7:0]       code,
   input  logic             ten,
   input  logic [LEN_W-1:0] left,
   input  logic             ack_cur,
   output seq_state_t       nxt_state,
   output act_t             act,
   output logic             dec_left,
   output logic             ack_nxt,
   output logic             fin,
   output logic [1:0]       err_set,
   output logic             ctl_rst,
   output logic             push_rx,
   output logic             take_tx
);
   logic             wr_path, rd_path;
   logic [LEN_W-1:0] rem_after;

   assign rem_after = (code == ST_RD_ACK) ? left - 1'b1 : left;

   always_comb begin
      nxt_state = state;
      act       = A_STOP;
      dec_left  = 1'b0;
      ack_nxt   = ack_cur;
      fin       = 1'b0;
      err_set   = E_NONE;
      ctl_rst   = 1'b0;
      push_rx   = 1'b0;
      take_tx   = 1'b0;
      wr_path   = 1'b0;
      rd_path   = 1'b0;
      if (state != S_IDLE) begin
         case (code)
            ST_START, ST_RSTART: begin
               act       = A_ADDR1;
               nxt_state = S_WADDR1;
            end
            ST_WA_ACK, ST_RA_ACK: begin
               if (ten) begin
                  act       = A_ADDR2;
                  nxt_state = S_WADDR2;
               end else if (code == ST_WA_ACK) begin
                  wr_path = 1'b1;
               end else begin
                  rd_path = 1'b1;
               end
            end
            ST_WA2_ACK, ST_WD_ACK: wr_path = 1'b1;
            ST_RA2_ACK, ST_RD_ACK: rd_path = 1'b1;
            ST_RD_NACK: begin
               act       = A_RECV_STOP;
               push_rx   = 1'b1;
               dec_left  = (left != '0);
               nxt_state = S_IDLE;
               fin       = 1'b1;
            end
            ST_WA_NACK, ST_WD_NACK, ST_RA_NACK: begin
               nxt_state = S_IDLE;
               fin       = 1'b1;
               err_set   = E_NODEV;
            end
            default: begin
               nxt_state = S_IDLE;
               fin       = 1'b1;
               err_set   = E_IO;
               ctl_rst   = 1'b1;
            end
         endcase

         if (wr_path) begin
            if (left == '0) begin
               nxt_state = S_IDLE;
               fin       = 1'b1;
            end else begin
               act       = A_SEND;
               nxt_state = S_WSACK;
               dec_left  = 1'b1;
               take_tx   = 1'b1;
            end
         end

         if (rd_path) begin
            if (code != ST_RD_ACK && left == '0) begin
               nxt_state = S_IDLE;
               fin       = 1'b1;
            end else begin
               if (code == ST_RD_ACK) begin
                  act      = A_RECV;
                  push_rx  = 1'b1;
                  dec_left = 1'b1;
               end else begin
                  act = A_CONT;
               end
               nxt_state = S_WDATA;
               if (rem_after == LEN_W'(1)) ack_nxt = 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/i2cseq_engine.sv
`timescale 1ns/1ps
module i2cseq_engine
   import i2cseq_pkg::*;
#(
   parameter int LEN_W  = 8,
   parameter bit TEN_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [9:0]       cmd_addr,
   input  logic             cmd_ten,
   input  logic             cmd_rd,
   input  logic [LEN_W-1:0] cmd_len,
   input  logic             st_valid,
   input  logic [7:0]       st_code,
   input  logic [7:0]       st_rx_byte,
   output logic             act_valid,
   output logic [2:0]       act_code,
   output logic [7:0]       act_byte,
   output logic             act_ack,
   output logic             ctrl_reset,
   input  logic [7:0]       tx_byte,
   output logic             tx_take,
   output logic             rx_valid,
   output logic [7:0]       rx_data,
   output logic             done,
   output logic [1:0]       err_code
);
   generate
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("i2cseq_engine: LEN_W must be 1..16");
      end
   endgenerate

   seq_state_t       state_q, nxt_state;
   act_t             nxt_act;
   logic [LEN_W-1:0] left_q;
   logic             ten_q, ack_q;
   logic [7:0]       addr1_q, addr2_q;
   logic             ten_eff;
   logic [7:0]       fmt_b1, fmt_b2;
   logic             dec_left, ack_nxt, fin, ctl_rst, push_rx, take_tx;
   logic [1:0]       err_set;
   logic             accept;

   assign cmd_ready = (state_q == S_IDLE);
   assign accept    = cmd_valid && cmd_ready;

   i2cseq_addr_fmt #(.TEN_EN(TEN_EN)) addr_fmt_i (
      .addr(cmd_addr), .ten_req(cmd_ten), .rd(cmd_rd),
      .ten_eff(ten_eff), .byte1(fmt_b1), .byte2(fmt_b2)
   );

   i2cseq_step #(.LEN_W(LEN_W)) step_i (
      .state(state_q), .code(st_code), .ten(ten_q), .left(left_q),
      .ack_cur(ack_q), .nxt_state(nxt_state), .act(nxt_act),
      .dec_left(dec_left), .ack_nxt(ack_nxt), .fin(fin),
      .err_set(err_set), .ctl_rst(ctl_rst), .push_rx(push_rx),
      .take_tx(take_tx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= S_IDLE;
         left_q     <= '0;
         ten_q      <= 1'b0;
         ack_q      <= 1'b1;
         addr1_q    <= '0;
         addr2_q    <= '0;
         act_valid  <= 1'b0;
         act_code   <= A_STOP;
         act_byte   <= '0;
         act_ack    <= 1'b1;
         ctrl_reset <= 1'b0;
         tx_take    <= 1'b0;
         rx_valid   <= 1'b0;
         rx_data    <= '0;
         done       <= 1'b0;
         err_code   <= E_NONE;
      end else begin
         act_valid  <= 1'b0;
         ctrl_reset <= 1'b0;
         tx_take    <= 1'b0;
         rx_valid   <= 1'b0;
         done       <= 1'b0;
         if (accept) begin
            state_q   <= S_WSTART;
            left_q    <= cmd_len;
            ten_q     <= ten_eff;
            ack_q     <= 1'b1;
            addr1_q   <= fmt_b1;
            addr2_q   <= fmt_b2;
            err_code  <= E_NONE;
            act_valid <= 1'b1;
            act_code  <= A_START;
            act_byte  <= '0;
            act_ack   <= 1'b1;
         end else if (st_valid) begin
            state_q   <= nxt_state;
            ack_q     <= ack_nxt;
            act_valid <= 1'b1;
            act_code  <= nxt_act;
            act_ack   <= ack_nxt;
            if (dec_left) left_q <= left_q - 1'b1;
            case (nxt_act)
               A_ADDR1: act_byte <= addr1_q;
               A_ADDR2: act_byte <= addr2_q;
               A_SEND:  act_byte <= tx_byte;
               default: act_byte <= '0;
            endcase
            tx_take    <= take_tx;
            rx_valid   <= push_rx;
            if (push_rx) rx_data <= st_rx_byte;
            done       <= fin;
            if (fin) err_code <= err_set;
            ctrl_reset <= ctl_rst;
         end
      end
   end

   // R12: completion is a single-cycle pulse
   p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R2: a taken request opens with START
   p_start_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (act_valid && act_code == A_START && !cmd_ready));
   // R10: controller reset only with an I/O error ending
   p_ctrl_rst_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_reset |-> (done && err_code == E_IO && act_code == A_STOP));
   // R5: the data source is only consumed by a SEND action
   p_take_with_send_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_take |-> (act_valid && act_code == A_SEND));
   // R6: received bytes only come with a receive action
   p_rx_with_recv_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> (act_valid && (act_code == A_RECV || act_code == A_RECV_STOP)));
   // R11: a stray status in idle gives only a stop
   p_idle_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && cmd_ready && !cmd_valid) |=>
         (act_valid && act_code == A_STOP && !done && $stable(err_code)));
endmodule

// File: tb/i2cseq_engine_tb_top.sv
`timescale 1ns/1ps
module i2cseq_engine_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0, cmd_ready;
   logic [9:0] cmd_addr = '0;
   logic       cmd_ten = 1'b0, cmd_rd = 1'b0;
   logic [7:0] cmd_len = '0;
   logic       st_valid = 1'b0;
   logic [7:0] st_code = '0, st_rx_byte = '0;
   logic       act_valid, act_ack, ctrl_reset, tx_take, rx_valid, done;
   logic [2:0] act_code;
   logic [7:0] act_byte, rx_data;
   logic [7:0] tx_byte = '0;
   logic [1:0] err_code;
   int total = 0, bad = 0;

   always #10 clk = ~clk;

   i2cseq_engine #(.LEN_W(8), .TEN_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_addr(cmd_addr), .cmd_ten(cmd_ten), .cmd_rd(cmd_rd), .cmd_len(cmd_len),
      .st_valid(st_valid), .st_code(st_code), .st_rx_byte(st_rx_byte),
      .act_valid(act_valid), .act_code(act_code), .act_byte(act_byte),
      .act_ack(act_ack), .ctrl_reset(ctrl_reset), .tx_byte(tx_byte),
      .tx_take(tx_take), .rx_valid(rx_valid), .rx_data(rx_data),
      .done(done), .err_code(err_code)
   );

   task automatic chk(input string req, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: got=%0h expected=%0h", req, got, exp);
      end
   endtask

   task automatic issue(input logic [9:0] a, input logic ten, input logic rd, input logic [7:0] len);
      @(negedge clk);
      cmd_addr = a; cmd_ten = ten; cmd_rd = rd; cmd_len = len; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R2 start act_valid", act_valid, 1);
      chk("R2 start code", act_code, 2);
      chk("R2 cmd_ready low", cmd_ready, 0);
      chk("R12 err cleared on accept", err_code, 0);
   endtask

   task automatic stat(input logic [7:0] c, input logic [7:0] rxb);
      @(negedge clk);
      st_code = c; st_rx_byte = rxb; st_valid = 1'b1;
      @(negedge clk);
      st_valid = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 cmd_ready", cmd_ready, 1);
      chk("R1 act_valid", act_valid, 0);
      chk("R1 done", done, 0);
      chk("R1 err", err_code, 0);
   endtask

   task automatic t_write7;
      issue(10'h052, 0, 0, 2);
      // request while busy must be ignored
      @(negedge clk);
      cmd_addr = 10'h011; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R2 busy request ignored", act_valid, 0);
      stat(8'h08, 0);
      chk("R3 addr1 code", act_code, 3);
      chk("R3 addr1 byte 7-bit write", act_byte, 8'hA4);
      tx_byte = 8'h11;
      stat(8'h18, 0);
      chk("R5 send code", act_code, 5);
      chk("R5 send byte", act_byte, 8'h11);
      chk("R5 tx_take", tx_take, 1);
      tx_byte = 8'h22;
      stat(8'h28, 0);
      chk("R5 second send byte", act_byte, 8'h22);
      stat(8'h28, 0);
      chk("R5 stop code", act_code, 0);
      chk("R5 done", done, 1);
      chk("R5 err ok", err_code, 0);
      @(negedge clk);
      chk("R12 done one cycle", done, 0);
   endtask

   task automatic t_read7;
      issue(10'h01D, 0, 1, 3);
      stat(8'h10, 0);
      chk("R3 repeated start addr1", act_byte, 8'h3B);
      stat(8'h40, 0);
      chk("R6 continue code", act_code, 1);
      chk("R6 ack with 3 left", act_ack, 1);
      stat(8'h50, 8'hA1);
      chk("R6 recv code", act_code, 6);
      chk("R6 rx_valid", rx_valid, 1);
      chk("R6 rx_data", rx_data, 8'hA1);
      chk("R6 ack with 2 left", act_ack, 1);
      stat(8'h50, 8'hA2);
      chk("R6 rx_data 2", rx_data, 8'hA2);
      chk("R6 ack dropped, 1 left", act_ack, 0);
      stat(8'h58, 8'hA3);
      chk("R7 recv_stop code", act_code, 7);
      chk("R7 rx_data last", rx_data, 8'hA3);
      chk("R7 done", done, 1);
      chk("R7 err ok", err_code, 0);
   endtask

   task automatic t_probe;
      issue(10'h030, 0, 1, 0);
      stat(8'h08, 0);
      stat(8'h40, 0);
      chk("R8 probe stop", act_code, 0);
      chk("R8 probe done", done, 1);
      chk("R8 probe err", err_code, 0);
      chk("R8 probe no rx", rx_valid, 0);
   endtask

   task automatic t_ten_write;
      issue(10'h2B5, 1, 0, 1);
      stat(8'h08, 0);
      chk("R4 10-bit addr1 write", act_byte, 8'hF4);
      stat(8'h18, 0);
      chk("R4 addr2 code", act_code, 4);
      chk("R4 addr2 byte", act_byte, 8'hB5);
      tx_byte = 8'h5A;
      stat(8'hD0, 0);
      chk("R5 send after addr2", act_code, 5);
      chk("R5 send byte after addr2", act_byte, 8'h5A);
      stat(8'h28, 0);
      chk("R5 10-bit stop done", done, 1);
   endtask

   task automatic t_ten_read;
      issue(10'h1C3, 1, 1, 1);
      stat(8'h08, 0);
      chk("R4 10-bit addr1 read", act_byte, 8'hF3);
      stat(8'h40, 0);
      chk("R4 read addr2 code", act_code, 4);
      chk("R4 read addr2 byte", act_byte, 8'hC3);
      stat(8'hE0, 0);
      chk("R6 continue after addr2", act_code, 1);
      chk("R6 single byte nack", act_ack, 0);
      stat(8'h58, 8'h77);
      chk("R7 10-bit last byte", rx_data, 8'h77);
      chk("R7 10-bit done", done, 1);
   endtask

   task automatic t_nack;
      issue(10'h055, 0, 0, 1);
      stat(8'h08, 0);
      stat(8'h20, 0);
      chk("R9 stop on addr nack", act_code, 0);
      chk("R9 done", done, 1);
      chk("R9 nodev", err_code, 1);
      repeat (3) @(negedge clk);
      chk("R12 err holds", err_code, 1);
      issue(10'h055, 0, 1, 2);
      stat(8'h08, 0);
      stat(8'h48, 0);
      chk("R9 read nack nodev", err_code, 1);
      issue(10'h055, 0, 0, 2);
      stat(8'h08, 0);
      stat(8'h18, 0);
      stat(8'h30, 0);
      chk("R9 data nack nodev", err_code, 1);
      chk("R9 data nack done", done, 1);
   endtask

   task automatic t_bus_err;
      issue(10'h066, 0, 0, 1);
      stat(8'h08, 0);
      stat(8'h00, 0);
      chk("R10 stop", act_code, 0);
      chk("R10 ctrl_reset", ctrl_reset, 1);
      chk("R10 err io", err_code, 2);
      chk("R10 done", done, 1);
   endtask

   task automatic t_idle_status;
      stat(8'h28, 0);
      chk("R11 act_valid", act_valid, 1);
      chk("R11 stop code", act_code, 0);
      chk("R11 no done", done, 0);
      chk("R11 err unchanged", err_code, 2);
      chk("R11 still idle", cmd_ready, 1);
   endtask

   initial begin
      #2000000;
      bad++; total++;
      $display("FAIL watchdog: got=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write7();
      t_read7();
      t_probe();
      t_ten_write();
      t_ten_read();
      t_nack();
      t_bus_err();
      t_idle_status();
      issue(10'h012, 0, 0, 0);
      repeat (2) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule